// File: doc/BRIEF.md
# Protected Row Write Commit Controller

This block sits behind a serial memory protocol engine and handles the write side of a memory command. Once the engine has received the command header and the two-byte start address, the block accepts data bytes into a one-row latch. Each received byte is tagged with a valid bit. The offset inside the row advances after every byte and wraps within the row. The row number itself never changes during a command.

Nothing reaches the array until the engine reports a Stop in the slot that directly follows a data-byte acknowledge. On that pulse the block starts a self-timed write cycle and raises `busy`. It then walks the latch and presents each valid entry on a valid/ready array write port. The cycle ends when the cycle timer has expired and every entry has been presented. At that point `busy` falls and the valid mask is cleared.

A write-control pin guards the top quarter of the address space. Its level is accumulated over the header window, from the command start up to and including the address strobe. If the pin was high at any point in that window, entries whose address falls in the top quarter are dropped. An abort, a Stop in any other slot, or a new start all discard the pending bytes. The pin must be tied low at the board when writes are always wanted.

Back-pressure rules:
- `din_ready` is high only while the block is collecting data bytes. A byte is taken on a clock edge where `din_valid` and `din_ready` are both high.
- On the array port, a write is taken on a clock edge where `arr_valid` and `arr_ready` are both high. While `arr_ready` is low, `arr_valid`, `arr_addr` and `arr_data` stay unchanged, and the write cycle is extended for as long as needed.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy`, `arr_valid` and `din_ready` are all low.
- R2: `din_ready` is high only in the data phase. The data phase begins on the cycle after `addr_valid` is sampled in the header phase. The header phase itself is entered by `cmd_start` while idle. Each valid&ready edge stores exactly one byte.
- R3: The k-th byte of a command (k counted from 0) is targeted at address {`addr_in`[ADDR_W-1:5], (`addr_in`[4:0]+k) mod 32}. The upper address bits (b12..b5 by default) never change during a command.
- R4: When more than 32 bytes are sent, the last byte for a given offset wins. Only offsets that received a byte are written, each exactly once; the other locations in the row are untouched.
- R5: `stop_commit` starts a write cycle only in the data phase and only after at least one byte has been received. The following all discard the pending bytes with no array write: `stop_commit` in the header phase, `cmd_abort`, and a `cmd_start` during the data phase (the last one begins a new header).
- R6: If `wc_pin` is high on any sampled cycle from `cmd_start` through the `addr_valid` cycle, no address whose two top bits are 11 (0x1800..0x1FFF by default) is written. Addresses below the top quarter are written regardless of `wc_pin`.
- R7: `wc_pin` has no effect after the `addr_valid` cycle.
- R8: `busy` rises on the cycle after the committing `stop_commit`. With `arr_ready` held high and WCYC_CLKS ≥ 33, `busy` stays high for exactly WCYC_CLKS cycles. While busy, `din_ready` is low and `cmd_start` is ignored.
- R9: While `arr_valid` is high and `arr_ready` is low, the array port holds its address and data. Every valid entry is still written, with `busy` extended beyond WCYC_CLKS where needed.
- R10: After a write cycle the valid mask is empty. A following one-byte command produces exactly one array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pulse: start of a write command header |
| addr_valid | input | 1 | Pulse: two address bytes complete, `addr_in` valid |
| addr_in | input | ADDR_W | Start byte address |
| din_valid | input | 1 | Data byte valid |
| din_data | input | DATA_W | Data byte |
| din_ready | output | 1 | Block is collecting data bytes |
| stop_commit | input | 1 | Pulse: Stop seen in the slot after a data acknowledge |
| cmd_abort | input | 1 | Pulse: command abandoned |
| wc_pin | input | 1 | Write-control level, high protects the top quarter |
| arr_valid | output | 1 | Array write request |
| arr_ready | input | 1 | Array accepts the write |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench builds the block with the default 13-bit address and 32-byte row, and shortens the write cycle to WCYC_CLKS = 40. With these values the exact busy length can be counted cycle by cycle, and a full shadow of the 8192-byte array can be compared after every command. The short cycle lets the bench sweep every start offset in a row against lengths of 1, 7, 32 and 33 bytes, which covers every wrap point and the overrun case. The protection tests use rows on both sides of the top-quarter boundary, with the write-control pin high at different points inside and outside the header window.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HDR   = 2'd1,
    PH_DATA  = 2'd2,
    PH_CYCLE = 2'd3
  } phase_t;
endpackage

// File: rtl/pgwr_hdr_ctl.sv
module pgwr_hdr_ctl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_start,
  input  logic                    addr_valid,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    din_fire,
  input  logic                    stop_commit,
  input  logic                    cmd_abort,
  input  logic                    wc_pin,
  input  logic                    any_valid,
  input  logic                    cyc_done,
  output phase_t                  phase,
  output logic                    wp_lat,
  output logic [ADDR_W-OFF_W-1:0] row_q,
  output logic [OFF_W-1:0]        off_q,
  output logic                    go,
  output logic                    clr
);
  localparam int ROW_W = ADDR_W - OFF_W;

  logic in_data;
  logic data_kill;

  assign in_data   = (phase == PH_DATA);
  assign data_kill = in_data && (cmd_abort || cmd_start || (stop_commit && !any_valid));
  assign go        = in_data && !cmd_abort && !cmd_start && stop_commit && any_valid;
  assign clr       = data_kill || ((phase == PH_CYCLE) && cyc_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      wp_lat <= 1'b0;
      row_q  <= '0;
      off_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (cmd_start) begin
            phase  <= PH_HDR;
            wp_lat <= wc_pin;
          end
        end
        PH_HDR: begin
          if (cmd_abort || stop_commit) begin
            phase <= PH_IDLE;
          end else if (cmd_start) begin
            wp_lat <= wc_pin;
          end else if (addr_valid) begin
            phase  <= PH_DATA;
            wp_lat <= wp_lat | wc_pin;
            row_q  <= addr_in[ADDR_W-1:OFF_W];
            off_q  <= addr_in[OFF_W-1:0];
          end else begin
            wp_lat <= wp_lat | wc_pin;
          end
        end
        PH_DATA: begin
          if (cmd_abort) begin
            phase <= PH_IDLE;
          end else if (cmd_start) begin
            phase  <= PH_HDR;
            wp_lat <= wc_pin;
          end else if (stop_commit) begin
            phase <= any_valid ? PH_CYCLE : PH_IDLE;
          end else if (din_fire) begin
            off_q <= off_q + 1'b1;
          end
        end
        default: begin
          if (cyc_done) phase <= PH_IDLE;
        end
      endcase
    end
  end

  logic unused_row_w;
  assign unused_row_w = (ROW_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/pgwr_row_latch.sv
module pgwr_row_latch #(
  parameter int ROW_BYTES = 32,
  parameter int DATA_W    = 8,
  localparam int OFF_W    = $clog2(ROW_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [OFF_W-1:0]            wr_off,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        clr,
  output logic [ROW_BYTES*DATA_W-1:0] data_flat,
  output logic [ROW_BYTES-1:0]        mask
);
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_ent
    logic [DATA_W-1:0] d_q;
    logic              v_q;
    logic              hit;

    assign hit = wr && (wr_off == OFF_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (clr) begin
        v_q <= 1'b0;
      end else if (hit) begin
        v_q <= 1'b1;
        d_q <= wr_data;
      end
    end

    assign mask[g]                         = v_q;
    assign data_flat[g*DATA_W +: DATA_W]   = d_q;
  end
endmodule

// File: rtl/pgwr_commit_seq.sv
module pgwr_commit_seq #(
  parameter int ADDR_W    = 13,
  parameter int ROW_BYTES = 32,
  parameter int DATA_W    = 8,
  parameter int WCYC_CLKS = 40,
  localparam int OFF_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = ADDR_W - OFF_W,
  localparam int TMR_W    = $clog2(WCYC_CLKS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic                        wp_lat,
  input  logic [ROW_W-1:0]            row_q,
  input  logic [ROW_BYTES-1:0]        mask,
  input  logic [ROW_BYTES*DATA_W-1:0] data_flat,
  input  logic                        arr_ready,
  output logic                        arr_valid,
  output logic [ADDR_W-1:0]           arr_addr,
  output logic [DATA_W-1:0]           arr_data,
  output logic                        cyc_done
);
  logic             active;
  logic [TMR_W-1:0] timer;
  logic [OFF_W-1:0] idx;
  logic             scan_done;
  logic             cur_prot;
  logic             emit;
  logic             step;

  assign arr_addr  = {row_q, idx};
  assign arr_data  = data_flat[idx*DATA_W +: DATA_W];
  assign cur_prot  = wp_lat && (arr_addr[ADDR_W-1 -: 2] == 2'b11);
  assign emit      = active && !scan_done && mask[idx] && !cur_prot;
  assign arr_valid = emit;
  assign step      = active && !scan_done && (!emit || arr_ready);
  assign cyc_done  = active && scan_done && (timer == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      timer     <= '0;
      idx       <= '0;
      scan_done <= 1'b0;
    end else if (go) begin
      active    <= 1'b1;
      timer     <= TMR_W'(WCYC_CLKS - 1);
      idx       <= '0;
      scan_done <= 1'b0;
    end else if (active) begin
      if (timer != '0) timer <= timer - 1'b1;
      if (step) begin
        if (idx == OFF_W'(ROW_BYTES - 1)) scan_done <= 1'b1;
        else                              idx       <= idx + 1'b1;
      end
      if (cyc_done) active <= 1'b0;
    end
  end
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int ROW_BYTES = 32,
  parameter int DATA_W    = 8,
  parameter int WCYC_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic              din_ready,
  input  logic              stop_commit,
  input  logic              cmd_abort,
  input  logic              wc_pin,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy
);
  localparam int OFF_W = $clog2(ROW_BYTES);
  localparam int ROW_W = ADDR_W - OFF_W;

  phase_t                       phase;
  logic                         wp_lat;
  logic [ROW_W-1:0]             row_q;
  logic [OFF_W-1:0]             off_q;
  logic                         go;
  logic                         clr;
  logic                         cyc_done;
  logic                         din_fire;
  logic [ROW_BYTES-1:0]         mask;
  logic [ROW_BYTES*DATA_W-1:0]  data_flat;

  assign din_ready = (phase == PH_DATA);
  assign din_fire  = din_valid && din_ready && !stop_commit && !cmd_abort && !cmd_start;
  assign busy      = (phase == PH_CYCLE);

  pgwr_hdr_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_hdr (
    .clk, .rst_n, .cmd_start, .addr_valid, .addr_in, .din_fire,
    .stop_commit, .cmd_abort, .wc_pin,
    .any_valid (|mask),
    .cyc_done, .phase, .wp_lat, .row_q, .off_q, .go, .clr
  );

  pgwr_row_latch #(.ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W)) u_lat (
    .clk, .rst_n,
    .wr      (din_fire),
    .wr_off  (off_q),
    .wr_data (din_data),
    .clr, .data_flat, .mask
  );

  pgwr_commit_seq #(
    .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W), .WCYC_CLKS(WCYC_CLKS)
  ) u_seq (
    .clk, .rst_n, .go, .wp_lat, .row_q, .mask, .data_flat, .arr_ready,
    .arr_valid, .arr_addr, .arr_data, .cyc_done
  );
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              stop_commit,
  input logic              din_ready,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_data,
  input logic              busy,
  input logic              wp_lat,
  input logic [ROW_W-1:0]  row_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !busy && !arr_valid && !din_ready); // R1
  AST_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) arr_valid |-> busy); // R5
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(stop_commit)); // R5
  AST_ROW_FIXED: assert property (@(posedge clk) disable iff (!rst_n) arr_valid |-> arr_addr[ADDR_W-1 -: ROW_W] == row_q); // R3
  AST_TOP_GUARDED: assert property (@(posedge clk) disable iff (!rst_n) arr_valid && wp_lat |-> arr_addr[ADDR_W-1 -: 2] != 2'b11); // R6
  AST_NO_INTAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !din_ready); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) busy && cmd_start |=> !din_ready); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n) arr_valid && !arr_ready |=> arr_valid && $stable(arr_addr) && $stable(arr_data)); // R9
endmodule

bind pgwr_commit pgwr_commit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ADDR_W - $clog2(ROW_BYTES))
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .stop_commit(stop_commit),
  .din_ready(din_ready), .arr_valid(arr_valid), .arr_ready(arr_ready),
  .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy),
  .wp_lat(wp_lat), .row_q(row_q)
);

// File: tb/pgwr_commit_tb_top.sv
module pgwr_commit_tb_top;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int RB = 32;
  localparam int WC = 40;
  localparam int MEM = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, addr_valid = 0, din_valid = 0, stop_commit = 0, cmd_abort = 0, wc_pin = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] din_data = '0;
  logic din_ready, arr_valid, busy;
  logic arr_ready = 1'b1;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int checks = 0, fails = 0, got_cnt = 0;
  bit done_flag = 0;
  logic [7:0] exp_mem [MEM];
  logic [7:0] got_mem [MEM];
  bit bp_en = 0;
  int bp_ph = 0;

  always #10 clk = ~clk;

  pgwr_commit #(.ADDR_W(AW), .ROW_BYTES(RB), .DATA_W(DW), .WCYC_CLKS(WC)) dut_i (
    .clk, .rst_n, .cmd_start, .addr_valid, .addr_in, .din_valid, .din_data, .din_ready,
    .stop_commit, .cmd_abort, .wc_pin, .arr_valid, .arr_ready, .arr_addr, .arr_data, .busy
  );

  always @(posedge clk)
    if (arr_valid && arr_ready) begin
      got_mem[arr_addr] <= arr_data;
      got_cnt <= got_cnt + 1;
    end

  always @(negedge clk) begin
    bp_ph <= bp_ph + 1;
    arr_ready <= !bp_en || ((bp_ph % 3) != 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < MEM; i++) if (exp_mem[i] !== got_mem[i]) d++;
    return d;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 7 + k * 13 + 1) & 255);
  endfunction

  // expected effect of n bytes from start address a, arithmetically
  function automatic int model(input logic [AW-1:0] a, input int n, input int seed, input bit prot);
    int cnt = 0;
    bit seen [RB];
    for (int k = 0; k < RB; k++) seen[k] = 0;
    for (int k = 0; k < n; k++) begin
      int off = (int'(a[4:0]) + k) % RB;
      logic [AW-1:0] ad = {a[AW-1:5], 5'(off)};
      if (!(prot && ad[AW-1:AW-2] == 2'b11)) begin
        exp_mem[ad] = pat(seed, k);
        if (!seen[off]) cnt++;
        seen[off] = 1;
      end
    end
    return cnt;
  endfunction

  task automatic header(input logic [AW-1:0] a, input bit w0, input bit w1, input bit w2);
    @(negedge clk); cmd_start = 1; wc_pin = w0;
    @(negedge clk); cmd_start = 0; wc_pin = w1;
    @(negedge clk); addr_valid = 1; addr_in = a; wc_pin = w2;
    @(negedge clk); addr_valid = 0; wc_pin = 0;
  endtask

  task automatic bytes(input int n, input int seed, input bit wdat);
    int miss = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      din_valid = 1; din_data = pat(seed, k); wc_pin = wdat;
      if (!din_ready) miss++;
    end
    @(negedge clk); din_valid = 0; wc_pin = 0;
    chk("R2 din_ready during data", miss, 0);
  endtask

  task automatic commit(output int bcnt);
    stop_commit = 1;
    @(negedge clk); stop_commit = 0;
    bcnt = 0;
    while (busy && bcnt < 1000) begin bcnt++; @(negedge clk); end
  endtask

  task automatic full_cmd(input string req, input logic [AW-1:0] a, input int n, input int seed,
                          input bit w0, input bit w1, input bit w2, input bit wdat);
    int ec, bc;
    got_cnt = 0;
    header(a, w0, w1, w2);
    bytes(n, seed, wdat);
    ec = model(a, n, seed, w0 | w1 | w2);
    commit(bc);
    chk({req, " memory"}, mem_diff(), 0);
    chk({req, " write count"}, got_cnt, ec);
    if (!bp_en) chk("R8 busy length", bc, WC);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int bc;
    for (int i = 0; i < MEM; i++) begin exp_mem[i] = 0; got_mem[i] = 0; end
    @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 arr_valid at reset", int'(arr_valid), 0);
    chk("R1 din_ready at reset", int'(din_ready), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2: ready low in header, not opened without start
    @(negedge clk); addr_valid = 1; addr_in = 13'h0040;
    @(negedge clk); addr_valid = 0;
    chk("R2 no data phase without start", int'(din_ready), 0);

    // basic single byte and page
    full_cmd("R3 single byte", 13'h0123, 1, 3, 0, 0, 0, 0);
    full_cmd("R3 wrap page", 13'h0234, 32, 4, 0, 0, 0, 0);
    // R10 mask cleared: one byte after a full page writes once
    full_cmd("R10 single after page", 13'h0230, 1, 5, 0, 0, 0, 0);
    // R4 overrun
    full_cmd("R4 overrun 45 bytes", 13'h0555, 45, 6, 0, 0, 0, 0);

    // R6 protection, various window points
    full_cmd("R6 top, wc at start", 13'h1810, 8, 7, 1, 0, 0, 0);
    full_cmd("R6 top, wc mid window", 13'h1FF0, 20, 8, 0, 1, 0, 0);
    full_cmd("R6 top, wc on addr cycle", 13'h1C00, 32, 9, 0, 0, 1, 0);
    full_cmd("R6 below top, wc high", 13'h17E0, 32, 10, 1, 1, 1, 1);
    full_cmd("R6 top, wc low", 13'h1800, 32, 11, 0, 0, 0, 0);
    // R7 wc during data only
    full_cmd("R7 top, wc only in data", 13'h1A3C, 10, 12, 0, 0, 0, 1);

    // R5 abort
    got_cnt = 0;
    header(13'h0300, 0, 0, 0);
    bytes(5, 13, 0);
    cmd_abort = 1; @(negedge clk); cmd_abort = 0;
    chk("R5 abort leaves data phase", int'(din_ready), 0);
    stop_commit = 1; @(negedge clk); stop_commit = 0;
    @(negedge clk);
    chk("R5 abort no busy", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R5 abort no writes", got_cnt, 0);
    chk("R5 abort memory", mem_diff(), 0);

    // R5 stop in header
    @(negedge clk); cmd_start = 1;
    @(negedge clk); cmd_start = 0; stop_commit = 1;
    @(negedge clk); stop_commit = 0; addr_valid = 1; addr_in = 13'h0400;
    @(negedge clk); addr_valid = 0;
    chk("R5 stop in header discards", int'(din_ready), 0);

    // R5 stop with no data bytes
    header(13'h0500, 0, 0, 0);
    stop_commit = 1; @(negedge clk); stop_commit = 0;
    @(negedge clk);
    chk("R5 stop without bytes no busy", int'(busy), 0);

    // R5 restart discards first command
    got_cnt = 0;
    header(13'h0600, 0, 0, 0);
    bytes(6, 14, 0);
    full_cmd("R5 restart keeps second only", 13'h0700, 4, 15, 0, 0, 0, 0);

    // R8 start ignored while busy
    got_cnt = 0;
    header(13'h0800, 0, 0, 0);
    bytes(3, 16, 0);
    void'(model(13'h0800, 3, 16, 0));
    stop_commit = 1; @(negedge clk); stop_commit = 0;
    repeat (3) @(negedge clk);
    cmd_start = 1; @(negedge clk); cmd_start = 0;
    chk("R8 busy holds on start", int'(busy), 1);
    while (busy) @(negedge clk);
    addr_valid = 1; addr_in = 13'h0900; @(negedge clk); addr_valid = 0;
    chk("R8 start during busy ignored", int'(din_ready), 0);
    chk("R8 memory after busy", mem_diff(), 0);

    // R9 back-pressure
    bp_en = 1;
    got_cnt = 0;
    header(13'h0A00, 0, 0, 0);
    bytes(32, 17, 0);
    void'(model(13'h0A00, 32, 17, 0));
    commit(bc);
    bp_en = 0;
    chk("R9 busy extended", int'(bc > WC), 1);
    chk("R9 stalled writes land", mem_diff(), 0);
    chk("R9 write count", got_cnt, 32);

    // sweep: every offset, lengths around the row size
    for (int o = 0; o < RB; o++) begin
      for (int li = 0; li < 4; li++) begin
        int n = (li == 0) ? 1 : (li == 1) ? 7 : (li == 2) ? 32 : 33;
        int r = (o * 5 + li * 11) % 192;
        logic [AW-1:0] a = {8'(r), 5'(o)};
        full_cmd("R3 R4 sweep", a, n, o * 4 + li, li[0], 0, 0, 0);
      end
    end
    // sweep top quarter with protection across rows
    for (int r = 190; r < 196; r++) begin
      full_cmd("R6 boundary sweep", {8'(r), 5'(r % 32)}, 12, r, 0, 1, 0, 0);
    end

    finish_run();
  end
endmodule